// File: doc/BRIEF.md
# Flash Chip-Erase Sequencer

This block runs the whole-array erase procedure for a word-wide flash device. It acts as master on a simple request/ready bus and is started by a one-cycle pulse. It issues a two-write erase command and then leaves the bus idle for a programmable number of clock cycles while the erase proceeds. After that it checks every word in turn, from the lowest address up. Each check is a verify command write that carries the word address, followed by a read of that same word.

A word passes only when the read returns all ones. When a word fails, the sequencer issues the erase command again. After the wait it continues checking at the word that failed, not at address zero, so words already checked are not read again. A retry limit stops an array that does not erase. Whether the sequence ends in success or in failure, it sends a double all-ones reset command so that the device returns to normal read mode. It then pulses done and holds the pass/fail flag and the number of re-erases until the next start.

A bus watchdog protects against a device that never answers. If a request stays unanswered too long, the sequence is abandoned and reported as failed.

Top module: `flash_erase_seq`

## Requirements
- R1: A bus request (bus_wr_o or bus_rd_o, never both) holds its address and write data unchanged until a cycle in which bus_ready_i is high; the transfer completes at that clock edge.
- R2: A sequence starts with the erase command: two writes of data 0x0020 to address 0.
- R3: After the second erase write completes, both request lines stay low for exactly ERASE_CYCLES cycles, and the next request is the verify command write.
- R4: A verify step is a write of 0x00A0 with the word address on bus_addr_o, followed directly by a read of the same address.
- R5: A verify read of 0xFFFF (all ones) passes the word. The next word, one address higher, is then checked. A pass on the highest address ends the sequence with fail_o low.
- R6: A verify read that is not all ones, while the retry count is below MAX_RETRY, increments retries_o and reissues the erase command. After the wait, verification continues at the same address.
- R7: A failing verify read when retries_o already equals MAX_RETRY ends the sequence with fail_o high, and the termination command is still issued.
- R8: Every completed sequence ends with two writes of 0xFFFF to address 0, after which done_o rises.
- R9: done_o is high for exactly one cycle. busy_o is high from the cycle after start_i is accepted until done_o. fail_o and retries_o hold their values until the next accepted start. No request is made while busy_o is low.
- R10: A start_i pulse while busy_o is high has no effect on the bus sequence or on the results.
- R11: A request left unanswered for BUS_TIMEOUT consecutive cycles is withdrawn. The block then pulses done_o with fail_o high, issues no further request, and does not send the termination command.
- R12: After reset, busy_o, done_o, fail_o, retries_o, bus_wr_o and bus_rd_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result of the last sequence: 1 means failed |
| retries_o | output | $clog2(MAX_RETRY+2) | Number of re-erases in the last sequence |
| bus_addr_o | output | ADDR_W | Word address of the request |
| bus_wdata_o | output | DATA_W | Write data |
| bus_wr_o | output | 1 | Write request |
| bus_rd_o | output | 1 | Read request |
| bus_rdata_i | input | DATA_W | Read data, valid with bus_ready_i |
| bus_ready_i | input | 1 | Completes the pending request |

## Verification
The hardest situation to reach is a second or later verify failure partway through the array. In that case the sequencer must resume at the failing word rather than at address zero, and its retry count must reach the limit at exactly the right verify. The bench creates this with a behavioural flash model. The model gives selected words a number of erases they need before they read all ones, and it counts completed erase pairs, so one run can produce several mid-array failures at different addresses. Other runs push one word past the retry limit, or withhold ready entirely to trip the bus watchdog.

// File: rtl/fes_pkg.sv
`timescale 1ns/1ps
package fes_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ERASE_A,
        S_ERASE_B,
        S_SETTLE,
        S_VCMD,
        S_VREAD,
        S_TERM_A,
        S_TERM_B
    } fes_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    typedef enum logic [1:0] {
        V_NEXT,
        V_LAST,
        V_RETRY,
        V_GIVEUP
    } verdict_e;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;

endpackage

// File: rtl/fes_busmap.sv
`timescale 1ns/1ps
module fes_busmap
    import fes_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  fes_state_e           state_i,
    input  logic [ADDR_W-1:0]    vaddr_i,
    output bus_op_e              op_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [DATA_W-1:0]    wdata_o
);

    always_comb begin
        op_o    = OP_NONE;
        addr_o  = '0;
        wdata_o = '0;
        unique case (state_i)
            S_ERASE_A, S_ERASE_B: begin
                op_o    = OP_WRITE;
                wdata_o = DATA_W'(CMD_ERASE);
            end
            S_VCMD: begin
                op_o    = OP_WRITE;
                addr_o  = vaddr_i;
                wdata_o = DATA_W'(CMD_VERIFY);
            end
            S_VREAD: begin
                op_o   = OP_READ;
                addr_o = vaddr_i;
            end
            S_TERM_A, S_TERM_B: begin
                op_o    = OP_WRITE;
                wdata_o = '1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fes_verdict.sv
`timescale 1ns/1ps
module fes_verdict
    import fes_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int RETRY_W   = 4,
    parameter int MAX_RETRY = 8
) (
    input  logic [DATA_W-1:0]  rdata_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [RETRY_W-1:0] retries_i,
    output verdict_e           verdict_o
);

    logic erased;
    logic last_word;
    logic retry_left;

    assign erased     = &rdata_i;
    assign last_word  = &addr_i;
    assign retry_left = retries_i != RETRY_W'(MAX_RETRY);

    always_comb begin
        if (erased)
            verdict_o = last_word ? V_LAST : V_NEXT;
        else
            verdict_o = retry_left ? V_RETRY : V_GIVEUP;
    end

endmodule

// File: rtl/flash_erase_seq.sv
`timescale 1ns/1ps
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 16,
    parameter int ERASE_CYCLES = 1000,
    parameter int BUS_TIMEOUT  = 64,
    parameter int MAX_RETRY    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           fail_o,
    output logic [$clog2(MAX_RETRY+2)-1:0] retries_o,
    output logic [ADDR_W-1:0]              bus_addr_o,
    output logic [DATA_W-1:0]              bus_wdata_o,
    output logic                           bus_wr_o,
    output logic                           bus_rd_o,
    input  logic [DATA_W-1:0]              bus_rdata_i,
    input  logic                           bus_ready_i
);

    localparam int RETRY_W = $clog2(MAX_RETRY + 2);
    localparam int CNT_MAX = (ERASE_CYCLES > BUS_TIMEOUT) ? ERASE_CYCLES : BUS_TIMEOUT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        fes_state_e         state;
        logic [ADDR_W-1:0]  vaddr;
        logic [RETRY_W-1:0] retries;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               fail;
    } seq_t;

    seq_t r_q, r_d;

    bus_op_e  op;
    verdict_e verdict;
    logic     xfer_ok;
    logic     timed_out;

    fes_busmap #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_busmap (
        .state_i (r_q.state),
        .vaddr_i (r_q.vaddr),
        .op_o    (op),
        .addr_o  (bus_addr_o),
        .wdata_o (bus_wdata_o)
    );

    fes_verdict #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .RETRY_W   (RETRY_W),
        .MAX_RETRY (MAX_RETRY)
    ) u_verdict (
        .rdata_i   (bus_rdata_i),
        .addr_i    (r_q.vaddr),
        .retries_i (r_q.retries),
        .verdict_o (verdict)
    );

    assign xfer_ok   = (op != OP_NONE) && bus_ready_i;
    assign timed_out = (op != OP_NONE) && !bus_ready_i &&
                       (r_q.cnt == CNT_W'(BUS_TIMEOUT - 1));

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (op != OP_NONE)
            r_d.cnt = xfer_ok ? '0 : r_q.cnt + CNT_W'(1);

        unique case (r_q.state)
            S_IDLE: begin
                if (start_i) begin
                    r_d.state   = S_ERASE_A;
                    r_d.vaddr   = '0;
                    r_d.retries = '0;
                    r_d.fail    = 1'b0;
                    r_d.cnt     = '0;
                end
            end
            S_ERASE_A: begin
                if (xfer_ok) r_d.state = S_ERASE_B;
            end
            S_ERASE_B: begin
                if (xfer_ok) begin
                    r_d.state = S_SETTLE;
                    r_d.cnt   = CNT_W'(ERASE_CYCLES - 1);
                end
            end
            S_SETTLE: begin
                if (r_q.cnt == '0) begin
                    r_d.state = S_VCMD;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_VCMD: begin
                if (xfer_ok) r_d.state = S_VREAD;
            end
            S_VREAD: begin
                if (xfer_ok) begin
                    unique case (verdict)
                        V_NEXT: begin
                            r_d.vaddr = r_q.vaddr + ADDR_W'(1);
                            r_d.state = S_VCMD;
                        end
                        V_LAST: r_d.state = S_TERM_A;
                        V_RETRY: begin
                            r_d.retries = r_q.retries + RETRY_W'(1);
                            r_d.state   = S_ERASE_A;
                        end
                        V_GIVEUP: begin
                            r_d.fail  = 1'b1;
                            r_d.state = S_TERM_A;
                        end
                        default: ;
                    endcase
                end
            end
            S_TERM_A: begin
                if (xfer_ok) r_d.state = S_TERM_B;
            end
            S_TERM_B: begin
                if (xfer_ok) begin
                    r_d.state = S_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: r_d.state = S_IDLE;
        endcase

        if (timed_out) begin
            r_d.state = S_IDLE;
            r_d.done  = 1'b1;
            r_d.fail  = 1'b1;
            r_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, vaddr: '0, retries: '0, cnt: '0,
                     done: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = r_q.state != S_IDLE;
    assign done_o    = r_q.done;
    assign fail_o    = r_q.fail;
    assign retries_o = r_q.retries;
    assign bus_wr_o  = op == OP_WRITE;
    assign bus_rd_o  = op == OP_READ;

endmodule

// File: rtl/fes_chk.sv
`timescale 1ns/1ps
module fes_chk #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BUS_TIMEOUT = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              done_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [DATA_W-1:0] bus_wdata_o,
    input logic              bus_wr_o,
    input logic              bus_rd_o,
    input logic              bus_ready_i
);

    logic [31:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            wait_q <= '0;
        else if ((bus_wr_o || bus_rd_o) && !bus_ready_i)
            wait_q <= wait_q + 32'd1;
        else
            wait_q <= '0;
    end

    p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_o && bus_rd_o));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr_o || bus_rd_o) && !bus_ready_i) |=>
        (done_o || ((bus_wr_o || bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o))));

    p_readpair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_o) |->
        ($past(bus_wr_o) && ($past(bus_wdata_o[7:0]) == 8'hA0) && $stable(bus_addr_o)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!bus_wr_o && !bus_rd_o));

    p_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_o || bus_rd_o) |-> (wait_q < BUS_TIMEOUT));

endmodule

bind flash_erase_seq fes_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .BUS_TIMEOUT (BUS_TIMEOUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_wr_o    (bus_wr_o),
    .bus_rd_o    (bus_rd_o),
    .bus_ready_i (bus_ready_i)
);

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int EC = 5;
    localparam int BT = 6;
    localparam int MR = 2;
    localparam int NW = 1 << AW;
    localparam int RW = $clog2(MR + 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          busy_o, done_o, fail_o;
    logic [RW-1:0] retries_o;
    logic [AW-1:0] bus_addr_o;
    logic [DW-1:0] bus_wdata_o;
    logic          bus_wr_o, bus_rd_o;
    logic [DW-1:0] bus_rdata_i = '0;
    logic          bus_ready_i = 1'b0;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .BUS_TIMEOUT(BT), .MAX_RETRY(MR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
        .fail_o(fail_o), .retries_o(retries_o), .bus_addr_o(bus_addr_o),
        .bus_wdata_o(bus_wdata_o), .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o),
        .bus_rdata_i(bus_rdata_i), .bus_ready_i(bus_ready_i)
    );

    typedef struct {
        bit            is_rd;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        string         tag;
    } txn_t;

    txn_t expq[$];
    int   need[NW];
    int   exp_retries;
    bit   exp_fail;
    int   lat;
    bit   never;
    int   wait_ctr;
    int   erase_writes;
    int   done_seen;
    bit   done_prev;
    bit   after_e2;
    int   idle_cnt;
    int   hold_ctr;
    int   checks = 0;
    int   errors = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_w(logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        txn_t t;
        t.is_rd = 1'b0; t.a = a; t.d = d; t.tag = tag;
        expq.push_back(t);
    endtask

    task automatic push_r(logic [AW-1:0] a, string tag);
        txn_t t;
        t.is_rd = 1'b1; t.a = a; t.d = '0; t.tag = tag;
        expq.push_back(t);
    endtask

    // Behavioural expectation of the bus conversation for the current need[] map
    task automatic build_expect();
        int  e, a, r;
        bit  resumed;
        expq.delete();
        push_w('0, 16'h0020, "R2");
        push_w('0, 16'h0020, "R2");
        e = 1; a = 0; r = 0; resumed = 0;
        forever begin
            push_w(AW'(a), 16'h00A0, resumed ? "R6" : "R4");
            push_r(AW'(a), "R4");
            resumed = 0;
            if (e >= need[a]) begin
                if (a == NW - 1) begin exp_fail = 0; break; end
                a++;
            end else if (r == MR) begin
                exp_fail = 1; break;
            end else begin
                r++; e++; resumed = 1;
                push_w('0, 16'h0020, "R6");
                push_w('0, 16'h0020, "R6");
            end
        end
        exp_retries = r;
        push_w('0, 16'hFFFF, "R8");
        push_w('0, 16'hFFFF, "R8");
    endtask

    // Flash model and per-clock comparison against the expected conversation
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                done_seen++;
                check(!done_prev, "R9", "done wider than one cycle", 1, 0);
            end
            done_prev = done_o;
            check(!(bus_wr_o && bus_rd_o), "R1", "both request lines", 1, 0);
            if (after_e2) begin
                if (bus_wr_o || bus_rd_o) begin
                    check(idle_cnt == EC, "R3", "erase wait cycles", idle_cnt, EC);
                    after_e2 = 0;
                end else begin
                    idle_cnt++;
                end
            end
            if (!(bus_wr_o || bus_rd_o)) begin
                bus_ready_i = 1'b0;
                bus_rdata_i = '0;
                wait_ctr = 0;
            end else if (!never && wait_ctr == lat) begin
                bus_ready_i = 1'b1;
                bus_rdata_i = '0;
                if (bus_rd_o)
                    bus_rdata_i = (erase_writes / 2 >= need[bus_addr_o]) ? 16'hFFFF : 16'h5A5A;
                if (expq.size() == 0) begin
                    check(0, "R8", "unexpected transfer", {bus_rd_o, bus_addr_o, bus_wdata_o}, 0);
                end else begin
                    txn_t t;
                    t = expq.pop_front();
                    check((bus_rd_o == t.is_rd) && (bus_addr_o == t.a) &&
                          (t.is_rd || bus_wdata_o == t.d), t.tag, "transfer {rd,addr,data}",
                          {bus_rd_o, bus_addr_o, (bus_rd_o ? 16'h0 : bus_wdata_o)},
                          {t.is_rd, t.a, (t.is_rd ? 16'h0 : t.d)});
                end
                if (bus_wr_o && bus_wdata_o == 16'h0020) begin
                    erase_writes++;
                    if (erase_writes % 2 == 0) begin
                        after_e2 = 1;
                        idle_cnt = 0;
                    end
                end
                wait_ctr = 0;
            end else begin
                bus_ready_i = 1'b0;
                wait_ctr++;
                hold_ctr++;
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic run(int l, bit nev, bit extra_start);
        int n;
        lat = l; never = nev; erase_writes = 0; done_seen = 0; hold_ctr = 0;
        after_e2 = 0;
        if (nev) begin
            expq.delete(); exp_fail = 1; exp_retries = 0;
        end else begin
            build_expect();
        end
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
        check(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);
        n = 0;
        while (!done_o && n < 20000) begin
            if (extra_start && n == 10) begin
                check(busy_o == 1'b1, "R10", "busy when second start given", busy_o, 1);
                start_i = 1'b1;
                cyc();
                start_i = 1'b0;
            end else begin
                cyc();
            end
            n++;
        end
        check(done_o == 1'b1, "R9", "done reached", done_o, 1);
        check(fail_o == exp_fail, nev ? "R11" : (exp_fail ? "R7" : "R5"), "fail flag", fail_o, exp_fail);
        check(retries_o == RW'(exp_retries), "R6", "retry count", retries_o, exp_retries);
        check(busy_o == 1'b0, "R9", "busy low at done", busy_o, 0);
        cyc();
        check(done_o == 1'b0, "R9", "done dropped", done_o, 0);
        check(done_seen == 1, extra_start ? "R10" : "R9", "done pulses", done_seen, 1);
        check(expq.size() == 0, "R8", "expected transfers left", expq.size(), 0);
        check(!bus_wr_o && !bus_rd_o, "R11", "bus quiet after done", {bus_wr_o, bus_rd_o}, 0);
        if (nev)
            check(hold_ctr == BT, "R11", "unanswered request cycles", hold_ctr, BT);
        repeat (3) cyc();
        check(fail_o == exp_fail && retries_o == RW'(exp_retries), "R9", "results held",
              {fail_o, retries_o}, {exp_fail, RW'(exp_retries)});
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL R9 watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) need[i] = 1;
        lat = 0; never = 0; wait_ctr = 0; done_prev = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        cyc();
        check(!busy_o && !done_o && !fail_o && retries_o == '0 && !bus_wr_o && !bus_rd_o,
              "R12", "reset state", {busy_o, done_o, fail_o, retries_o, bus_wr_o, bus_rd_o}, 0);

        // Clean array, immediate ready
        run(0, 0, 0);

        // Two mid-array failures, recovered within the limit; extra start while busy
        for (int i = 0; i < NW; i++) need[i] = 1;
        need[3] = 2;
        need[6] = 3;
        run(1, 0, 1);

        // One word beyond the retry limit
        for (int i = 0; i < NW; i++) need[i] = 1;
        need[5] = 4;
        run(2, 0, 0);

        // Last word needs one re-erase, slow ready
        for (int i = 0; i < NW; i++) need[i] = 1;
        need[NW-1] = 2;
        run(3, 0, 0);

        // Device never answers
        run(0, 1, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule